// File: doc/BRIEF.md
# Stacked-Board Hit Stream Forwarder

This block sits on each board of a stack of identical front-end boards. It forwards hit data up the stack, from the bottom board to a single head board. It merges two sources onto one byte-wide output link. The first source is hit records from the board's own collector, each carrying a channel byte and a time byte. The second source is the byte stream arriving from the board below. Every local hit leaves the board as a three-byte record:

- a header byte holding this board's 4-bit address in its low nibble, with the high nibble zero;
- the channel byte;
- the time byte.

Records received from below are relayed byte for byte, without change. The link carries no framing signal, so every three accepted bytes make one record.

Incoming chain bytes first enter a small forwarding FIFO. A round-robin arbiter then chooses between the FIFO and the local collector, one record at a time, so the three bytes of a record are never split. Two configuration pins set the board's role in the stack:

- A bottom board refuses all input from below.
- A top board sends the merged stream to the host port instead of the link toward the board above.

Both valid/ready handshakes stall cleanly under backpressure.

Top module: `fwd_chain_top`

## Requirements
- R1: After reset, `chain_out_valid`, `host_valid` and `loc_ready` are low, and `up_ready` is high on a board that is not the bottom board.
- R2: A local hit is sent as three bytes in this order: `{4'b0000, cfg_addr}`, then `loc_chan`, then `loc_time`. Local hits leave in the order they were accepted.
- R3: Bytes accepted on the upstream input leave the board unchanged and in the same order. Every accepted record is eventually delivered.
- R4: The output never interleaves records. Once the first byte of a record is sent, the next two bytes sent belong to that same record.
- R5: When both sources hold a complete record at a record boundary, service alternates between them. The source that presented a record first is locked in and sent first.
- R6: While the active output's valid is high and its ready is low, the valid stays high and the byte stays unchanged in the next cycle.
- R7: The forwarding FIFO accepts exactly `FWD_DEPTH` bytes while the output is stalled, then drops `up_ready` low. No accepted byte is lost.
- R8: With `cfg_bottom` high, `up_ready` stays low and `up_valid` has no effect on the output stream.
- R9: With `cfg_top` high, the stream appears on the `host_*` port and `chain_out_valid` stays low. With `cfg_top` low, `host_valid` stays low.
- R10: `loc_ready` is high only in the cycle in which the time byte (the third byte) of that local record is accepted at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 4 | Static board address inserted in local headers |
| cfg_bottom | input | 1 | Board is bottom of stack; upstream input disabled |
| cfg_top | input | 1 | Board is head of stack; output routed to host port |
| loc_valid | input | 1 | Local collector offers a hit |
| loc_chan | input | 8 | Channel of offered hit |
| loc_time | input | 8 | Time of offered hit |
| loc_ready | output | 1 | Local hit consumed (pulses on its last byte) |
| up_valid | input | 1 | Byte offered by board below |
| up_byte | input | 8 | Byte from board below |
| up_ready | output | 1 | Forwarding FIFO can accept a byte |
| chain_out_valid | output | 1 | Byte offered to board above |
| chain_out_byte | output | 8 | Byte to board above |
| chain_out_ready | input | 1 | Board above accepts the byte |
| host_valid | output | 1 | Byte offered to host interface |
| host_byte | output | 8 | Byte to host interface |
| host_ready | input | 1 | Host accepts the byte |

## Verification
Several properties are checked on every cycle by assertions:

- the output holds under a stall;
- `loc_ready` pulses only on a record's final byte;
- the FIFO never overflows;
- a bottom board keeps its upstream input closed;
- at most one output port is active at a time.

Other properties can only be shown by the bench's scenarios. These are the byte content and ordering of local and forwarded records, the alternation pattern under contention, and the exact FIFO capacity. The bench checks them against queues it models itself while the input rates and output backpressure vary randomly.

// File: rtl/fwd_chain_pkg.sv
package fwd_chain_pkg;
    localparam int ADDR_W    = 4;
    localparam int LINK_W    = 8;
    localparam int REC_BYTES = 3;
    localparam int SLOT_W    = $clog2(REC_BYTES);

    typedef logic [LINK_W-1:0] link_byte_t;
    typedef logic [ADDR_W-1:0] board_addr_t;

    typedef enum logic {
        SRC_LOCAL = 1'b0,
        SRC_CHAIN = 1'b1
    } src_e;

    typedef struct packed {
        link_byte_t chan;
        link_byte_t tstamp;
    } hit_rec_t;

    localparam logic [SLOT_W-1:0] SLOT_HDR  = SLOT_W'(0);
    localparam logic [SLOT_W-1:0] SLOT_CHAN = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(REC_BYTES - 1);

    function automatic link_byte_t make_header(input board_addr_t a);
        return {{(LINK_W-ADDR_W){1'b0}}, a};
    endfunction

    function automatic src_e other_src(input src_e s);
        return (s == SRC_LOCAL) ? SRC_CHAIN : SRC_LOCAL;
    endfunction
endpackage

// File: rtl/fwd_byte_fifo.sv
module fwd_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr, rd_ptr;

    assign empty   = (wr_ptr == rd_ptr);
    assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign rd_data = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty);
endmodule

// File: rtl/fwd_rr_merger.sv
module fwd_rr_merger
    import fwd_chain_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  link_byte_t  hdr_byte,
    input  logic        loc_valid,
    input  hit_rec_t    loc_rec,
    output logic        loc_ready,
    input  logic        fwd_valid,
    input  link_byte_t  fwd_data,
    output logic        fwd_pop,
    output logic        out_valid,
    output link_byte_t  out_byte,
    input  logic        out_ready
);
    logic              in_rec_q;
    src_e              owner_q, last_q, pick, cur;
    logic [SLOT_W-1:0] slot_q;
    logic              xfer;

    always_comb begin
        if (loc_valid && fwd_valid) pick = other_src(last_q);
        else if (loc_valid)         pick = SRC_LOCAL;
        else                        pick = SRC_CHAIN;
        cur       = in_rec_q ? owner_q : pick;
        out_valid = (cur == SRC_LOCAL) ? loc_valid : fwd_valid;
        if (cur == SRC_CHAIN) begin
            out_byte = fwd_data;
        end else begin
            unique case (slot_q)
                SLOT_HDR:  out_byte = hdr_byte;
                SLOT_CHAN: out_byte = loc_rec.chan;
                default:   out_byte = loc_rec.tstamp;
            endcase
        end
        xfer      = out_valid && out_ready;
        fwd_pop   = xfer && (cur == SRC_CHAIN);
        loc_ready = xfer && (cur == SRC_LOCAL) && (slot_q == SLOT_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_rec_q <= 1'b0;
            owner_q  <= SRC_LOCAL;
            last_q   <= SRC_CHAIN;
            slot_q   <= SLOT_HDR;
        end else if (xfer) begin
            if (slot_q == SLOT_LAST) begin
                in_rec_q <= 1'b0;
                slot_q   <= SLOT_HDR;
                last_q   <= cur;
            end else begin
                in_rec_q <= 1'b1;
                slot_q   <= slot_q + 1'b1;
                owner_q  <= cur;
            end
        end else if (out_valid) begin
            in_rec_q <= 1'b1;
            owner_q  <= cur;
        end
    end

    assert_hold_under_stall_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));
    assert_local_ack_last_R10: assert property (@(posedge clk) disable iff (rst)
        loc_ready |-> (out_valid && out_ready && loc_valid));
    assert_slot_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        slot_q <= SLOT_LAST);
endmodule

// File: rtl/fwd_out_router.sv
module fwd_out_router
    import fwd_chain_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_top,
    input  logic       in_valid,
    input  link_byte_t in_byte,
    output logic       in_ready,
    output logic       link_valid,
    output link_byte_t link_byte,
    input  logic       link_ready,
    output logic       host_valid,
    output link_byte_t host_byte,
    input  logic       host_ready
);
    always_comb begin
        link_valid = in_valid && !cfg_top;
        host_valid = in_valid &&  cfg_top;
        link_byte  = cfg_top ? '0 : in_byte;
        host_byte  = cfg_top ? in_byte : '0;
        in_ready   = cfg_top ? host_ready : link_ready;
    end

    assert_one_port_R9: assert property (@(posedge clk) disable iff (rst)
        !(link_valid && host_valid));
endmodule

// File: rtl/fwd_chain_top.sv
module fwd_chain_top
    import fwd_chain_pkg::*;
#(
    parameter int FWD_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] cfg_addr,
    input  logic       cfg_bottom,
    input  logic       cfg_top,
    input  logic       loc_valid,
    input  logic [7:0] loc_chan,
    input  logic [7:0] loc_time,
    output logic       loc_ready,
    input  logic       up_valid,
    input  logic [7:0] up_byte,
    output logic       up_ready,
    output logic       chain_out_valid,
    output logic [7:0] chain_out_byte,
    input  logic       chain_out_ready,
    output logic       host_valid,
    output logic [7:0] host_byte,
    input  logic       host_ready
);
    logic       fifo_full, fifo_empty, fifo_push, fifo_pop;
    link_byte_t fifo_head;
    hit_rec_t   loc_rec;
    logic       m_valid, m_ready;
    link_byte_t m_byte;

    assign up_ready  = !cfg_bottom && !fifo_full;
    assign fifo_push = up_valid && up_ready;
    assign loc_rec   = '{chan: loc_chan, tstamp: loc_time};

    fwd_byte_fifo #(.DEPTH(FWD_DEPTH), .WIDTH(LINK_W)) u_fifo (
        .clk(clk), .rst(rst),
        .wr_en(fifo_push), .wr_data(up_byte),
        .rd_en(fifo_pop), .rd_data(fifo_head),
        .empty(fifo_empty), .full(fifo_full)
    );

    fwd_rr_merger u_merge (
        .clk(clk), .rst(rst),
        .hdr_byte(make_header(cfg_addr)),
        .loc_valid(loc_valid), .loc_rec(loc_rec), .loc_ready(loc_ready),
        .fwd_valid(!fifo_empty), .fwd_data(fifo_head), .fwd_pop(fifo_pop),
        .out_valid(m_valid), .out_byte(m_byte), .out_ready(m_ready)
    );

    fwd_out_router u_route (
        .clk(clk), .rst(rst), .cfg_top(cfg_top),
        .in_valid(m_valid), .in_byte(m_byte), .in_ready(m_ready),
        .link_valid(chain_out_valid), .link_byte(chain_out_byte), .link_ready(chain_out_ready),
        .host_valid(host_valid), .host_byte(host_byte), .host_ready(host_ready)
    );

    assert_bottom_closed_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_bottom |-> !up_ready);
endmodule

// File: tb/fwd_chain_top_bench.sv
`timescale 1ns/1ps
module fwd_chain_top_bench;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] cfg_addr = 4'd5;
    logic cfg_bottom = 1'b0, cfg_top = 1'b0;
    logic loc_valid = 1'b0, loc_ready;
    logic [7:0] loc_chan = '0, loc_time = '0;
    logic up_valid = 1'b0, up_ready;
    logic [7:0] up_byte = '0;
    logic chain_out_valid, chain_out_ready = 1'b0;
    logic [7:0] chain_out_byte;
    logic host_valid, host_ready = 1'b0;
    logic [7:0] host_byte;

    always #2.5 clk = ~clk;

    fwd_chain_top #(.FWD_DEPTH(DEPTH)) u_fwd_chain_top (.*);

    int tests = 0, fails = 0;
    logic [15:0] lq[$], exp_loc[$];
    logic [7:0]  uq[$];
    logic [23:0] exp_fwd[$];
    bit          order_log[$];
    logic [7:0]  rb[3];
    int          pos = 0;
    bit loc_hs = 0, up_hs = 0, out_hs = 0, stall_prev = 0, junk_up = 0;
    logic [7:0] prev_b = '0;
    int loc_rate = 60, up_rate = 60, rdy_mode = 0, up_cnt = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] hdr(input logic [3:0] a);
        return {4'b0000, a};
    endfunction

    task automatic add_local(input int n);
        for (int i = 0; i < n; i++) begin
            logic [15:0] r = 16'($urandom);
            lq.push_back(r);
            exp_loc.push_back(r);
        end
    endtask

    task automatic add_fwd(input int n);
        for (int i = 0; i < n; i++) begin
            logic [3:0] a = 4'((32'(cfg_addr) + 1 + $urandom % 15) % 16);
            logic [23:0] r = {hdr(a), 16'($urandom)};
            uq.push_back(r[23:16]); uq.push_back(r[15:8]); uq.push_back(r[7:0]);
            exp_fwd.push_back(r);
        end
    endtask

    task automatic take_byte(input logic [7:0] b);
        rb[pos] = b;
        if (pos == 2) begin
            pos = 0;
            if (rb[0] == hdr(cfg_addr)) begin
                order_log.push_back(1'b1);
                if (exp_loc.size() == 0)
                    check(0, "R2", "unexpected local record", {rb[1], rb[2]}, 0);
                else begin
                    logic [15:0] e = exp_loc.pop_front();
                    check({rb[1], rb[2]} == e, "R2", "local record bytes", {rb[1], rb[2]}, e);
                end
            end else begin
                order_log.push_back(1'b0);
                if (exp_fwd.size() == 0)
                    check(0, "R3", "unexpected forwarded record", {rb[0], rb[1], rb[2]}, 0);
                else begin
                    logic [23:0] e = exp_fwd.pop_front();
                    check({rb[0], rb[1], rb[2]} == e, "R3/R4", "forwarded record bytes",
                          {rb[0], rb[1], rb[2]}, e);
                end
            end
        end else pos++;
    endtask

    task automatic step();
        logic ov, ordy;
        logic [7:0] ob;
        @(negedge clk);
        if (loc_hs) void'(lq.pop_front());
        if (up_hs)  void'(uq.pop_front());
        if (!(loc_valid && !loc_hs)) begin
            if (lq.size() > 0 && ($urandom % 100) < loc_rate) begin
                loc_valid = 1'b1; loc_chan = lq[0][15:8]; loc_time = lq[0][7:0];
            end else loc_valid = 1'b0;
        end
        if (junk_up) begin
            up_valid = 1'b1; up_byte = 8'($urandom);
        end else if (!(up_valid && !up_hs)) begin
            if (uq.size() > 0 && ($urandom % 100) < up_rate) begin
                up_valid = 1'b1; up_byte = uq[0];
            end else up_valid = 1'b0;
        end
        ordy = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : (($urandom % 100) < 70);
        chain_out_ready = ordy; host_ready = ordy;
        #1;
        loc_hs = loc_valid && loc_ready;
        up_hs  = up_valid && up_ready;
        ov = cfg_top ? host_valid : chain_out_valid;
        ob = cfg_top ? host_byte : chain_out_byte;
        out_hs = ov && ordy;
        if (stall_prev)
            check(ov && ob == prev_b, "R6", "output changed under stall", {ov, ob}, {1'b1, prev_b});
        stall_prev = ov && !ordy;
        prev_b = ob;
        if (cfg_top) check(!chain_out_valid, "R9", "link valid while top", chain_out_valid, 0);
        else         check(!host_valid, "R9", "host valid while not top", host_valid, 0);
        if (cfg_bottom) check(!up_ready, "R8", "up_ready on bottom board", up_ready, 0);
        if (loc_hs)
            check(out_hs && pos == 2 && rb[0] == hdr(cfg_addr), "R10",
                  "loc_ready not on final local byte", {out_hs, 8'(pos)}, {1'b1, 8'd2});
        if (out_hs) take_byte(ob);
        if (up_hs) up_cnt++;
    endtask

    task automatic do_reset(input logic [3:0] a, input bit bot, input bit top);
        @(negedge clk);
        rst = 1'b1; cfg_addr = a; cfg_bottom = bot; cfg_top = top;
        loc_valid = 0; up_valid = 0; chain_out_ready = 0; host_ready = 0;
        loc_hs = 0; up_hs = 0; out_hs = 0; stall_prev = 0; junk_up = 0; pos = 0;
        lq.delete(); uq.delete(); exp_loc.delete(); exp_fwd.delete(); order_log.delete();
        up_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic drain(input int lim);
        int n = 0;
        while ((lq.size() || uq.size() || exp_loc.size() || exp_fwd.size() || pos != 0) && n < lim) begin
            step(); n++;
        end
        check(n < lim, "R3", "records not all delivered", exp_loc.size() + exp_fwd.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state
        do_reset(4'd5, 1'b0, 1'b0);
        #1;
        check(!chain_out_valid && !host_valid && !loc_ready, "R1", "valids after reset",
              {chain_out_valid, host_valid, loc_ready}, 0);
        check(up_ready, "R1", "up_ready after reset", up_ready, 1);

        // R5: contention alternation, outputs stalled first
        do_reset(4'd3, 1'b0, 1'b0);
        loc_rate = 100; up_rate = 100; rdy_mode = 2;
        add_fwd(3); add_local(2);
        repeat (15) step();
        rdy_mode = 1;
        drain(200);
        check(order_log.size() == 5, "R5", "record count", order_log.size(), 5);
        if (order_log.size() == 5)
            check({order_log[0], order_log[1], order_log[2], order_log[3], order_log[4]} == 5'b10100,
                  "R5", "service order L,F,L,F,F",
                  {order_log[0], order_log[1], order_log[2], order_log[3], order_log[4]}, 5'b10100);

        // R7: FIFO capacity under a stalled output
        do_reset(4'd9, 1'b0, 1'b0);
        rdy_mode = 2; up_rate = 100;
        add_fwd(7);
        repeat (30) step();
        check(up_cnt == DEPTH, "R7", "bytes accepted while stalled", up_cnt, DEPTH);
        check(!up_ready, "R7", "up_ready with full FIFO", up_ready, 0);
        rdy_mode = 1;
        drain(300);

        // R2/R3/R4/R6: random traffic on a middle board
        do_reset(4'd5, 1'b0, 1'b0);
        loc_rate = 60; up_rate = 60; rdy_mode = 0;
        add_local(30); add_fwd(30);
        drain(5000);

        // R9: head board, random traffic to the host port
        do_reset(4'd12, 1'b0, 1'b1);
        loc_rate = 50; up_rate = 80; rdy_mode = 0;
        add_local(20); add_fwd(25);
        drain(5000);

        // R8: bottom board ignores upstream input
        do_reset(4'd0, 1'b1, 1'b0);
        junk_up = 1; loc_rate = 70; rdy_mode = 0;
        add_local(15);
        drain(3000);
        repeat (20) step();
        check(pos == 0 && exp_fwd.size() == 0 && up_cnt == 0, "R8", "upstream bytes leaked",
              up_cnt, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule